// File: doc/BRIEF.md
# Clock-Calendar Interrupt Unit

This block gathers the interrupt sources of a small timer that works in one of two modes and condenses them into four sticky flags and one request line. In clock mode, eight periodic update strobes (from quarter-second up to one year) are individually enabled and together set a single shared periodic flag. A field-selective alarm compares the current minute, hour and weekday against alarm values and sets its own flag. In compare-match mode, the periodic and alarm paths are switched off. Instead, counter overflow and compare-match strobes set their own flags.

The counters are not part of this block. Their activity arrives as one-cycle strobes, and the current time fields arrive as plain values. A small write port loads the periodic enables and a control word, which holds the mode and the three remaining enables. The same port clears flags by writing ones. The enables and the mode can only be changed while the run input is low, so software sets up the interrupts first and starts counting afterwards. No data stream passes through the block, so every pin is a plain control or status signal with no handshake.

Top module: `rtc_irq_unit`

## Requirements
- R1: While `rst_n` is low, and after reset, all four flags, all enables and the mode (clock mode) are 0, and `irq` is 0.
- R2: In clock mode with `run` high, a strobe on `per_strobe[i]` sets flag bit 0 (periodic) at the next clock edge when periodic enable bit i is 1. The strobe bits are 0 = quarter-second, 1 = half-second, 2 = second, 3 = minute, 4 = hour, 5 = day, 6 = month, 7 = year. A strobe whose enable bit is 0 has no effect.
- R3: The alarm matches when every field whose bit in `alm_fld_en` is 1 equals its current value. Bit 0 selects minute, bit 1 selects hour and bit 2 selects weekday. A field whose bit is 0 is ignored. When all three bits are 0, the alarm never matches.
- R4: In clock mode with `run` high, flag bit 1 (alarm) is set only in the cycle after the match goes from 0 to 1. A match that stays true does not set the flag again. The flag is set whether or not the alarm enable is 1.
- R5: In compare-match mode with `run` high, `tmr_ovf` sets flag bit 2 and `tmr_cmp` sets flag bit 3 at the next edge.
- R6: Sources of the inactive mode never set a flag. No source sets a flag while `run` is low.
- R7: `irq` is 1 exactly when the active mode has an asserted flag whose enable is 1. In clock mode these are: flag bit 0 with any periodic enable set, and flag bit 1 with the alarm enable. In compare-match mode these are: flag bit 2 with the overflow enable, and flag bit 3 with the compare enable. `irq` follows the flags and enables with no extra delay.
- R8: A write to address 0 loads the eight periodic enables. A write to address 1 loads the control word: bit 0 = mode (0 clock, 1 compare-match), bit 1 = alarm enable, bit 2 = overflow enable, bit 3 = compare enable. Both writes take effect at the next edge and are ignored while `run` is 1.
- R9: A write to address 2 clears every flag whose data bit is 1 (bit positions as flag bits 0 to 3), whatever the state of `run`. A set event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enabled; locks enables and mode when high |
| per_strobe | input | 8 | Periodic update strobes, quarter-second to year |
| tmr_ovf | input | 1 | Compare-match timer overflow strobe |
| tmr_cmp | input | 1 | Compare-match timer match strobe |
| cur_min | input | 7 | Current minute field |
| cur_hour | input | 6 | Current hour field |
| cur_wday | input | 3 | Current weekday field |
| alm_min | input | 7 | Alarm minute value |
| alm_hour | input | 6 | Alarm hour value |
| alm_wday | input | 3 | Alarm weekday value |
| alm_fld_en | input | 3 | Alarm field enables: minute, hour, weekday |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| flags | output | 4 | Sticky flags: periodic, alarm, overflow, compare |
| irq | output | 1 | Combined interrupt request |

## Verification
Each flag is due one edge after its strobe or match edge. The alarm takes no extra cycle, because its previous-match register only serves to detect the rising edge. A write to an enable or clear takes effect at the edge where it is sampled. `irq` is combinational from the flags and enables, so it is due in the same cycle as the flag or enable that causes it. The bench drives inputs on the falling edge and updates its reference model at each rising edge from the same inputs. It compares flags and `irq` at the next falling edge, which is exactly one register stage after the stimulus.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NFLAG = 4;
  localparam int FLG_PER = 0;
  localparam int FLG_ALM = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_CMP = 3;

  localparam int CTL_MODE = 0;
  localparam int CTL_ALM  = 1;
  localparam int CTL_OVF  = 2;
  localparam int CTL_CMP  = 3;
  localparam int CTL_W    = 4;

  typedef enum logic {MODE_CLOCK = 1'b0, MODE_CMT = 1'b1} mode_e;
endpackage

// File: rtl/rtc_irq_cfg.sv
module rtc_irq_cfg
  import rtc_irq_pkg::*;
#(
  parameter int NPER = 8,
  parameter int AW   = 2,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [NPER-1:0] per_en,
  output mode_e           mode,
  output logic            alm_en,
  output logic            ovf_en,
  output logic            cmp_en,
  output logic [NFLAG-1:0] clr_mask
);
  localparam logic [AW-1:0] ADDR_PER = AW'(0);
  localparam logic [AW-1:0] ADDR_CTL = AW'(1);
  localparam logic [AW-1:0] ADDR_CLR = AW'(2);

  logic [CTL_W-1:0] ctl_q;
  logic             cfg_wr_ok;

  assign cfg_wr_ok = wr_en && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_en <= '0;
      ctl_q  <= '0;
    end else if (cfg_wr_ok) begin
      if (wr_addr == ADDR_PER) per_en <= wr_data[NPER-1:0];
      if (wr_addr == ADDR_CTL) ctl_q  <= wr_data[CTL_W-1:0];
    end
  end

  assign mode     = mode_e'(ctl_q[CTL_MODE]);
  assign alm_en   = ctl_q[CTL_ALM];
  assign ovf_en   = ctl_q[CTL_OVF];
  assign cmp_en   = ctl_q[CTL_CMP];
  assign clr_mask = (wr_en && wr_addr == ADDR_CLR) ? wr_data[NFLAG-1:0] : '0;

  // R8: configuration is frozen while counting
  assert_locked_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run) |=> ($stable(per_en) && $stable(ctl_q)));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [WDAY_W-1:0] alm_wday,
  input  logic [2:0]        fld_en,
  output logic              fire
);
  localparam int NFLD = 3;

  logic [NFLD-1:0] fld_eq;
  logic [NFLD-1:0] fld_ok;
  logic            match;
  logic            match_q;

  assign fld_eq[0] = (cur_min  == alm_min);
  assign fld_eq[1] = (cur_hour == alm_hour);
  assign fld_eq[2] = (cur_wday == alm_wday);

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    assign fld_ok[f] = !fld_en[f] || fld_eq[f];
  end

  assign match = (|fld_en) && (&fld_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match;
  end

  assign fire = match && !match_q;

  // R4: one fire per match interval
  assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
#(
  parameter int NPER = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  mode_e            mode,
  input  logic [NPER-1:0]  per_strobe,
  input  logic [NPER-1:0]  per_en,
  input  logic             alm_fire,
  input  logic             alm_en,
  input  logic             tmr_ovf,
  input  logic             ovf_en,
  input  logic             tmr_cmp,
  input  logic             cmp_en,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic             clk_mode;
  logic             cmt_mode;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] en_vec;
  logic [NFLAG-1:0] act_vec;

  assign clk_mode = (mode == MODE_CLOCK);
  assign cmt_mode = (mode == MODE_CMT);

  assign set_vec[FLG_PER] = run && clk_mode && |(per_strobe & per_en);
  assign set_vec[FLG_ALM] = run && clk_mode && alm_fire;
  assign set_vec[FLG_OVF] = run && cmt_mode && tmr_ovf;
  assign set_vec[FLG_CMP] = run && cmt_mode && tmr_cmp;

  assign en_vec[FLG_PER]  = |per_en;
  assign en_vec[FLG_ALM]  = alm_en;
  assign en_vec[FLG_OVF]  = ovf_en;
  assign en_vec[FLG_CMP]  = cmp_en;

  assign act_vec[FLG_PER] = clk_mode;
  assign act_vec[FLG_ALM] = clk_mode;
  assign act_vec[FLG_OVF] = cmt_mode;
  assign act_vec[FLG_CMP] = cmt_mode;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] && !clr_mask[i]) || set_vec[i];
    end

    // R9: a set in the same cycle as a clear wins
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
  end

  assign irq = |(flags & en_vec & act_vec);

  // R7: a request always has a flag behind it
  assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int NPER   = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int WDAY_W = 3,
  parameter int AW     = 2,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NPER-1:0]   per_strobe,
  input  logic              tmr_ovf,
  input  logic              tmr_cmp,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [WDAY_W-1:0] alm_wday,
  input  logic [2:0]        alm_fld_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [3:0]        flags,
  output logic              irq
);
  logic [NPER-1:0]  per_en;
  mode_e            mode;
  logic             alm_en, ovf_en, cmp_en;
  logic [NFLAG-1:0] clr_mask;
  logic             alm_fire;

  rtc_irq_cfg #(.NPER(NPER), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_en(per_en), .mode(mode), .alm_en(alm_en),
    .ovf_en(ovf_en), .cmp_en(cmp_en), .clr_mask(clr_mask)
  );

  rtc_alarm_cmp #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAY_W(WDAY_W)) u_alarm (
    .clk(clk), .rst_n(rst_n),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_wday(alm_wday),
    .fld_en(alm_fld_en), .fire(alm_fire)
  );

  rtc_irq_flags #(.NPER(NPER)) u_flags (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .per_strobe(per_strobe), .per_en(per_en),
    .alm_fire(alm_fire), .alm_en(alm_en),
    .tmr_ovf(tmr_ovf), .ovf_en(ovf_en),
    .tmr_cmp(tmr_cmp), .cmp_en(cmp_en),
    .clr_mask(clr_mask), .flags(flags), .irq(irq)
  );

  // R3: an alarm flag needs at least one participating field
  assert_alarm_needs_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLG_ALM]) |-> $past(|alm_fld_en));

  // R6: compare-match flags only rise in compare-match mode with run high
  assert_cmt_mode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[FLG_OVF]) || $rose(flags[FLG_CMP])) |-> ($past(mode) == MODE_CMT && $past(run)));

  // R6: clock-mode flags only rise in clock mode with run high
  assert_clk_mode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[FLG_PER]) || $rose(flags[FLG_ALM])) |-> ($past(mode) == MODE_CLOCK && $past(run)));
endmodule

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] per_strobe = '0;
  logic       tmr_ovf = 1'b0, tmr_cmp = 1'b0;
  logic [6:0] cur_min = '0, alm_min = '0;
  logic [5:0] cur_hour = '0, alm_hour = '0;
  logic [2:0] cur_wday = '0, alm_wday = '0, alm_fld_en = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] flags;
  logic       irq;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  rtc_irq_unit u_rtc_irq_unit (
    .clk(clk), .rst_n(rst_n), .run(run), .per_strobe(per_strobe),
    .tmr_ovf(tmr_ovf), .tmr_cmp(tmr_cmp),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_wday(alm_wday),
    .alm_fld_en(alm_fld_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flags(flags), .irq(irq)
  );

  // Behavioural reference model
  bit [7:0] m_per;
  bit       m_mode, m_ae, m_oe, m_ce, m_prev;
  bit [3:0] m_flags;

  function automatic bit alarm_match();
    if (alm_fld_en == 3'b000) return 1'b0;
    if (alm_fld_en[0] && cur_min  != alm_min)  return 1'b0;
    if (alm_fld_en[1] && cur_hour != alm_hour) return 1'b0;
    if (alm_fld_en[2] && cur_wday != alm_wday) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit model_irq();
    if (!m_mode) return (m_flags[0] && m_per != 0) || (m_flags[1] && m_ae);
    return (m_flags[2] && m_oe) || (m_flags[3] && m_ce);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = '0; m_mode = 0; m_ae = 0; m_oe = 0; m_ce = 0;
      m_flags = '0; m_prev = 1'b1;
    end else begin
      bit mt;
      bit [3:0] setv, clrv;
      mt = alarm_match();
      setv = '0;
      if (run && !m_mode) begin
        setv[0] = (per_strobe & m_per) != 0;
        setv[1] = mt && !m_prev;
      end
      if (run && m_mode) begin
        setv[2] = tmr_ovf;
        setv[3] = tmr_cmp;
      end
      clrv = (wr_en && wr_addr == 2'd2) ? wr_data[3:0] : 4'b0;
      m_flags = (m_flags & ~clrv) | setv;
      if (wr_en && !run) begin
        if (wr_addr == 2'd0) m_per = wr_data;
        if (wr_addr == 2'd1) begin
          m_mode = wr_data[0]; m_ae = wr_data[1]; m_oe = wr_data[2]; m_ce = wr_data[3];
        end
      end
      m_prev = mt;
    end
  end

  // Compare on every falling edge after reset
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        tests++;
        if (flags[i] !== m_flags[i]) begin
          fails++;
          $display("FAIL %s flag bit %0d: actual %0b expected %0b", (i == 0) ? "R2" : (i == 1) ? "R4" : "R5",
                   i, flags[i], m_flags[i]);
        end
      end
      tests++;
      if (irq !== model_irq()) begin
        fails++;
        $display("FAIL R7 irq: actual %0b expected %0b", irq, model_irq());
      end
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {irq,flags}: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic pstrobe(input logic [7:0] s);
    per_strobe = s;
    tick(1);
    per_strobe = '0;
  endtask

  initial begin
    tick(1);
    chk("R1", {irq, flags}, 5'b0_0000);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R1", {irq, flags}, 5'b0_0000);

    // R6: overflow ignored in clock mode
    run = 1'b1;
    tmr_ovf = 1'b1; tmr_cmp = 1'b1; tick(1); tmr_ovf = 1'b0; tmr_cmp = 1'b0;
    chk("R6", {irq, flags}, 5'b0_0000);
    run = 1'b0;

    // R8: enables quarter-second and second; alarm enable
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h02);
    run = 1'b1;
    pstrobe(8'h02);
    chk("R2", {irq, flags}, 5'b0_0000);
    pstrobe(8'h04);
    chk("R2", {irq, flags}, 5'b1_0001);
    wr(2'd2, 8'h01);
    chk("R9", {irq, flags}, 5'b0_0000);
    // R9: set and clear in the same cycle
    per_strobe = 8'h01; wr(2'd2, 8'h01); per_strobe = '0;
    chk("R9", {irq, flags}, 5'b1_0001);
    wr(2'd2, 8'h0F);

    // R3/R4: alarm on minute and hour
    alm_min = 7'd30; alm_hour = 6'd12; alm_wday = 3'd3; alm_fld_en = 3'b011;
    cur_min = 7'd29; cur_hour = 6'd12; cur_wday = 3'd5;
    tick(2);
    cur_min = 7'd30;
    tick(1);
    chk("R3", {irq, flags}, 5'b1_0010);
    wr(2'd2, 8'h02);
    tick(3);
    chk("R4", {irq, flags}, 5'b0_0000);

    // R3: no field enabled never matches
    cur_min = 7'd31; alm_fld_en = 3'b000; tick(1);
    cur_min = 7'd30; tick(2);
    chk("R3", {irq, flags}, 5'b0_0000);
    // R3: weekday participating and mismatched
    alm_fld_en = 3'b111; cur_min = 7'd29; tick(1);
    cur_min = 7'd30; tick(2);
    chk("R3", {irq, flags}, 5'b0_0000);
    alm_fld_en = 3'b011; cur_min = 7'd29; tick(1);
    cur_min = 7'd30; tick(1);
    chk("R4", {irq, flags}, 5'b1_0010);

    // R8: writes ignored while running
    wr(2'd1, 8'h00);
    chk("R8", {irq, flags}, 5'b1_0010);
    run = 1'b0;
    wr(2'd1, 8'h00);
    chk("R7", {irq, flags}, 5'b0_0010);
    wr(2'd2, 8'h0F);
    // R4: flag sets with alarm interrupt disabled
    run = 1'b1;
    cur_min = 7'd29; tick(1);
    cur_min = 7'd30; tick(1);
    chk("R4", {irq, flags}, 5'b0_0010);
    run = 1'b0;

    // R5: compare-match mode, overflow enabled only
    wr(2'd1, 8'h05);
    run = 1'b1;
    chk("R7", {irq, flags}, 5'b0_0010);
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    chk("R5", {irq, flags}, 5'b1_0110);
    tmr_cmp = 1'b1; tick(1); tmr_cmp = 1'b0;
    chk("R5", {irq, flags}, 5'b1_1110);
    wr(2'd2, 8'h0F);
    // R6: clock sources ignored in compare-match mode
    pstrobe(8'hFF);
    cur_min = 7'd29; tick(1);
    cur_min = 7'd30; tick(1);
    chk("R6", {irq, flags}, 5'b0_0000);
    tmr_cmp = 1'b1; tick(1); tmr_cmp = 1'b0;
    chk("R7", {irq, flags}, 5'b0_1000);
    wr(2'd2, 8'h08);
    // R6: nothing sets while stopped
    run = 1'b0;
    tmr_ovf = 1'b1; tmr_cmp = 1'b1; tick(1); tmr_ovf = 1'b0; tmr_cmp = 1'b0;
    chk("R6", {irq, flags}, 5'b0_0000);

    // R1: reset mid-run clears everything
    run = 1'b1;
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    rst_n = 1'b0; tick(1);
    chk("R1", {irq, flags}, 5'b0_0000);
    rst_n = 1'b1; run = 1'b0; tick(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule